// File: doc/BRIEF.md
# Battery Pre-charge Scheme Controller

This block is the digital controller for a battery pre-charger. Analog comparators report whether an AC adapter or a USB bus is present, whether a battery pack is attached, and where the battery voltage sits relative to three thresholds (0.5 V, 2.0 V, 3.6 V). The controller picks one of three current schemes: a small trickle current, a slow constant current, or a fast dissipation-limited current. It also picks the supply path (AC or USB). When no battery is attached, it runs the constant-voltage start-up sequence.

Every comparator flag passes through a two-flop synchronizer and then through a stability filter. A flag is accepted only after it has held a new value for a set number of cycles, so comparator chatter cannot toggle the current scheme. The configuration bits (pre-charge off, accessory supply on, load-resistor disable) are synchronous register bits and act directly on the next state. Power-on reset is a synchronous, active-high reset.

Top module: `precharge_ctrl`

## Requirements
- R1: While `por` is high, and after it is released until a filtered flag changes, every output is 0.
- R2: The design acts on a comparator flag only after two synchronizer stages plus `STABLE` (default 4) consecutive cycles at the new value. A raw input change before clock edge n first affects the outputs after edge n+6. A pulse shorter than `STABLE` cycles has no effect.
- R3: With a battery present, a valid source, and the battery below 0.5 V (`bat_gt_low`=0), only `en_small` is set.
- R4: With a battery present and `bat_gt_low`=1, `en_slow` is set under two conditions. The first is an AC adapter, USB charger or car-kit with `bat_gt_mid`=0. The second is a USB host (`usb_host`=1) anywhere below 3.6 V.
- R5: `en_fast` is set only when `bat_gt_mid`=1, `bat_gt_top`=0, and the source is the AC adapter or a non-host USB source.
- R6: With a battery present and `bat_gt_top`=1, no current scheme is enabled.
- R7: With a battery present and `sys_active`=1, all pre-charge stops. It resumes once `sys_active` returns to 0.
- R8: If `pre_off` or `acc_sup_en` is 1, every output is 0 from the next edge on.
- R9: If the AC adapter is present, `sel_ac` is the selected path and `sel_usb` stays 0, whether or not USB is also present.
- R10: With USB only, nothing is enabled or selected while `ckit_det`=0.
- R11: With no battery and a non-host source (constant-voltage mode), the behaviour depends on the other flags. If `sys_active`=0 and the battery is below 3.6 V, only `en_small` runs. If `sys_active`=1, `cv_req` is set and no scheme runs. `load_en` is set throughout this mode unless `load_dis`=1. With a USB host and no battery, everything is off.
- R12: At most one of `en_small`, `en_slow` and `en_fast` is set at a time. Whenever one is set, exactly one of `sel_ac` and `sel_usb` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| chg_det | input | 1 | AC adapter present (async) |
| vbus_det | input | 1 | USB bus present (async) |
| bat_det | input | 1 | Battery pack attached (async) |
| bat_gt_low | input | 1 | Battery above 0.5 V (async) |
| bat_gt_mid | input | 1 | Battery above 2.0 V (async) |
| bat_gt_top | input | 1 | Battery above 3.6 V (async) |
| ckit_det | input | 1 | USB source typed as car-kit/charger/host; gates USB current (async) |
| usb_host | input | 1 | USB source is a host port rather than a dedicated charger (async) |
| sys_active | input | 1 | System in active state (async) |
| pre_off | input | 1 | Pre-charge disable bit |
| acc_sup_en | input | 1 | Accessory supply enable bit; blocks pre-charge |
| load_dis | input | 1 | Software disable of the load resistor |
| en_small | output | 1 | Small trickle-current scheme enable |
| en_slow | output | 1 | Slow constant-current scheme enable |
| en_fast | output | 1 | Fast dissipation-limited scheme enable |
| sel_ac | output | 1 | AC path selected |
| sel_usb | output | 1 | USB path selected |
| cv_req | output | 1 | Constant-voltage mode request |
| load_en | output | 1 | Load-resistor enable |

## Verification
The bench goes after the band edges: 2.0 V with an AC source versus a USB host, 3.6 V with a battery attached versus absent, and 0.5 V. At these edges a wrong band decode would pick the wrong scheme, for example fast current from a host port. A 3-cycle glitch on the top comparator checks the filter. A filter that counted short would drop fast charging on noise, and one that counted long would fail the cycle-exact model. Other runs exercise both sources present, USB before the car-kit flag, and the no-battery sequence. In each of these a wrong priority would drive both paths, source current from an untyped USB port, or assert the constant-voltage request before the system is up.

// File: rtl/pc_pkg.sv
package pc_pkg;
    localparam int NFLAG = 9;
    localparam int F_CHG  = 0;
    localparam int F_VBUS = 1;
    localparam int F_BAT  = 2;
    localparam int F_LOW  = 3;
    localparam int F_MID  = 4;
    localparam int F_TOP  = 5;
    localparam int F_CKIT = 6;
    localparam int F_HOST = 7;
    localparam int F_SYS  = 8;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SMALL   = 3'd1,
        ST_SLOW    = 3'd2,
        ST_FAST    = 3'd3,
        ST_CV_CHG  = 3'd4,
        ST_CV_HOLD = 3'd5,
        ST_CV_RUN  = 3'd6
    } pc_state_e;

    typedef struct packed {
        pc_state_e state;
        logic      sel_ac;
        logic      sel_usb;
        logic      load_en;
    } pc_regs_t;
endpackage

// File: rtl/pc_sync2.sv
module pc_sync2 #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] meta_d, meta_q, sync_d, sync_q;

    always_comb begin
        meta_d = din;
        sync_d = meta_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q;
endmodule

// File: rtl/pc_debounce.sv
module pc_debounce #(
    parameter int WIDTH  = 9,
    parameter int STABLE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int CW = $clog2(STABLE + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

    logic [WIDTH-1:0] filt_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [CW-1:0] cnt_d, cnt_q;
        logic          filt_d;

        always_comb begin
            cnt_d  = '0;
            filt_d = filt_q[i];
            if (din[i] != filt_q[i]) begin
                if (cnt_q == LAST) begin
                    filt_d = din[i];
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q     <= '0;
                filt_q[i] <= 1'b0;
            end else begin
                cnt_q     <= cnt_d;
                filt_q[i] <= filt_d;
            end
        end

        // R2: the filtered flag only moves toward the value its input held
        p_rise_follows_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(filt_q[i]) |-> $past(din[i]));
        p_fall_follows_r2: assert property (@(posedge clk) disable iff (rst)
            $fell(filt_q[i]) |-> !$past(din[i]));
    end

    assign dout = filt_q;
endmodule

// File: rtl/pc_sched_fsm.sv
module pc_sched_fsm
    import pc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] flag,
    input  logic             pre_off,
    input  logic             acc_sup_en,
    input  logic             load_dis,
    output logic             en_small,
    output logic             en_slow,
    output logic             en_fast,
    output logic             sel_ac,
    output logic             sel_usb,
    output logic             cv_req,
    output logic             load_en
);
    pc_regs_t r_d, r_q;

    logic src_ac, src_usb, dedicated, inhibit;

    always_comb begin
        src_ac    = flag[F_CHG];
        src_usb   = !flag[F_CHG] && flag[F_VBUS] && flag[F_CKIT];
        dedicated = src_ac || (src_usb && !flag[F_HOST]);
        inhibit   = pre_off || acc_sup_en || !(src_ac || src_usb);

        r_d = '{state: ST_IDLE, sel_ac: 1'b0, sel_usb: 1'b0, load_en: 1'b0};
        if (!inhibit) begin
            if (!flag[F_BAT]) begin
                if (dedicated) begin
                    if (flag[F_SYS])      r_d.state = ST_CV_RUN;
                    else if (flag[F_TOP]) r_d.state = ST_CV_HOLD;
                    else                  r_d.state = ST_CV_CHG;
                end
            end else if (!flag[F_SYS] && !flag[F_TOP]) begin
                if (!flag[F_LOW])      r_d.state = ST_SMALL;
                else if (!flag[F_MID]) r_d.state = ST_SLOW;
                else if (dedicated)    r_d.state = ST_FAST;
                else                   r_d.state = ST_SLOW;
            end
        end
        if (r_d.state != ST_IDLE) begin
            r_d.sel_ac  = src_ac;
            r_d.sel_usb = src_usb;
        end
        r_d.load_en = (r_d.state inside {ST_CV_CHG, ST_CV_HOLD, ST_CV_RUN}) && !load_dis;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_IDLE, sel_ac: 1'b0, sel_usb: 1'b0, load_en: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        en_small = (r_q.state == ST_SMALL) || (r_q.state == ST_CV_CHG);
        en_slow  = (r_q.state == ST_SLOW);
        en_fast  = (r_q.state == ST_FAST);
        cv_req   = (r_q.state == ST_CV_RUN);
        sel_ac   = r_q.sel_ac;
        sel_usb  = r_q.sel_usb;
        load_en  = r_q.load_en;
    end

    p_onehot_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({en_small, en_slow, en_fast}));
    p_en_has_sel_r12: assert property (@(posedge clk) disable iff (rst)
        (en_small || en_slow || en_fast) |-> (sel_ac ^ sel_usb));
    p_inhibit_r8: assert property (@(posedge clk) disable iff (rst)
        (pre_off || acc_sup_en) |=> !(en_small || en_slow || en_fast || sel_ac || sel_usb || cv_req || load_en));
    p_ac_prio_r9: assert property (@(posedge clk) disable iff (rst)
        flag[F_CHG] |=> !sel_usb);
    p_top_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (flag[F_BAT] && flag[F_TOP]) |=> !(en_small || en_slow || en_fast));
    p_sys_stop_r7: assert property (@(posedge clk) disable iff (rst)
        (flag[F_BAT] && flag[F_SYS]) |=> !(en_small || en_slow || en_fast));
    p_cv_req_r11: assert property (@(posedge clk) disable iff (rst)
        (!flag[F_BAT] && flag[F_SYS] && flag[F_CHG] && !pre_off && !acc_sup_en) |=> (cv_req && sel_ac));
endmodule

// File: rtl/precharge_ctrl.sv
module precharge_ctrl
    import pc_pkg::*;
#(
    parameter int STABLE = 4
) (
    input  logic clk,
    input  logic por,
    input  logic chg_det,
    input  logic vbus_det,
    input  logic bat_det,
    input  logic bat_gt_low,
    input  logic bat_gt_mid,
    input  logic bat_gt_top,
    input  logic ckit_det,
    input  logic usb_host,
    input  logic sys_active,
    input  logic pre_off,
    input  logic acc_sup_en,
    input  logic load_dis,
    output logic en_small,
    output logic en_slow,
    output logic en_fast,
    output logic sel_ac,
    output logic sel_usb,
    output logic cv_req,
    output logic load_en
);
    logic [NFLAG-1:0] raw, synced, filtered;

    always_comb begin
        raw         = '0;
        raw[F_CHG]  = chg_det;
        raw[F_VBUS] = vbus_det;
        raw[F_BAT]  = bat_det;
        raw[F_LOW]  = bat_gt_low;
        raw[F_MID]  = bat_gt_mid;
        raw[F_TOP]  = bat_gt_top;
        raw[F_CKIT] = ckit_det;
        raw[F_HOST] = usb_host;
        raw[F_SYS]  = sys_active;
    end

    pc_sync2 #(.WIDTH(NFLAG)) u_sync (
        .clk(clk), .rst(por), .din(raw), .dout(synced)
    );

    pc_debounce #(.WIDTH(NFLAG), .STABLE(STABLE)) u_filt (
        .clk(clk), .rst(por), .din(synced), .dout(filtered)
    );

    pc_sched_fsm u_fsm (
        .clk(clk), .rst(por), .flag(filtered),
        .pre_off(pre_off), .acc_sup_en(acc_sup_en), .load_dis(load_dis),
        .en_small(en_small), .en_slow(en_slow), .en_fast(en_fast),
        .sel_ac(sel_ac), .sel_usb(sel_usb), .cv_req(cv_req), .load_en(load_en)
    );

    p_reset_quiet_r1: assert property (@(posedge clk)
        por |=> !(en_small || en_slow || en_fast || sel_ac || sel_usb || cv_req || load_en));
endmodule

// File: tb/precharge_ctrl_tb.sv
module precharge_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic chg_det = 0, vbus_det = 0, bat_det = 0, bat_gt_low = 0, bat_gt_mid = 0;
    logic bat_gt_top = 0, ckit_det = 0, usb_host = 0, sys_active = 0;
    logic pre_off = 0, acc_sup_en = 0, load_dis = 0;
    logic en_small, en_slow, en_fast, sel_ac, sel_usb, cv_req, load_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string phase = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    precharge_ctrl u_dut (
        .clk(clk), .por(por), .chg_det(chg_det), .vbus_det(vbus_det), .bat_det(bat_det),
        .bat_gt_low(bat_gt_low), .bat_gt_mid(bat_gt_mid), .bat_gt_top(bat_gt_top),
        .ckit_det(ckit_det), .usb_host(usb_host), .sys_active(sys_active),
        .pre_off(pre_off), .acc_sup_en(acc_sup_en), .load_dis(load_dis),
        .en_small(en_small), .en_slow(en_slow), .en_fast(en_fast), .sel_ac(sel_ac),
        .sel_usb(sel_usb), .cv_req(cv_req), .load_en(load_en)
    );

    // Bench flag order: chg, vbus, bat, low, mid, top, ckit, host, sys (bit 0 = chg)
    function automatic logic [8:0] pack_raw();
        return {sys_active, usb_host, ckit_det, bat_gt_top, bat_gt_mid, bat_gt_low, bat_det, vbus_det, chg_det};
    endfunction

    // Outputs {small, slow, fast, ac, usb, cv, load} expected from settled flags
    function automatic logic [6:0] expect_of(logic [8:0] f, logic off, logic acc, logic ldis);
        logic ac, usb, ded;
        ac  = f[0];
        usb = !f[0] && f[1] && f[6];
        ded = ac || (usb && !f[7]);
        if (off || acc || !(ac || usb)) return 7'b0;
        if (!f[2]) begin
            if (!ded) return 7'b0;
            if (f[8]) return {3'b000, ac, usb, 1'b1, !ldis};
            if (f[5]) return {3'b000, ac, usb, 1'b0, !ldis};
            return {3'b100, ac, usb, 1'b0, !ldis};
        end
        if (f[8] || f[5]) return 7'b0;
        if (!f[3]) return {3'b100, ac, usb, 2'b00};
        if (!f[4] || !ded) return {3'b010, ac, usb, 2'b00};
        return {3'b001, ac, usb, 2'b00};
    endfunction

    logic [8:0] hist[$];
    logic [8:0] fmodel = '0;
    logic [6:0] exp_out = '0;

    always @(posedge clk) begin
        cycles++;
        if (por) begin
            hist.delete();
            for (int k = 0; k < 6; k++) hist.push_back(9'b0);
            fmodel  = '0;
            exp_out = '0;
        end else begin
            exp_out = expect_of(fmodel, pre_off, acc_sup_en, load_dis);
            for (int b = 0; b < 9; b++) begin
                logic same;
                same = 1'b1;
                for (int k = hist.size() - 5; k <= hist.size() - 2; k++)
                    if (hist[k][b] != hist[hist.size()-2][b]) same = 1'b0;
                if (same) fmodel[b] = hist[hist.size()-2][b];
            end
            hist.push_back(pack_raw());
            void'(hist.pop_front());
        end
    end

    function automatic logic [6:0] outs();
        return {en_small, en_slow, en_fast, sel_ac, sel_usb, cv_req, load_en};
    endfunction

    always @(negedge clk) begin
        checks++;
        if (outs() !== exp_out) begin
            errors++;
            $display("FAIL %s cycle %0d: outputs %b expected %b", phase, cycles, outs(), exp_out);
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(string tag, logic [6:0] want);
        checks++;
        if (outs() !== want) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b", tag, outs(), want);
        end
    endtask

    initial begin
        run(5);
        expect_now("R1 during reset", 7'b0);
        por = 1'b0;
        run(10);
        expect_now("R1 after release", 7'b0);

        phase = "R3"; chg_det = 1; bat_det = 1; run(12);
        expect_now("R3 small below 0.5V", 7'b100_10_00);
        phase = "R4"; bat_gt_low = 1; run(12);
        expect_now("R4 slow AC band", 7'b010_10_00);
        phase = "R5"; bat_gt_mid = 1; run(12);
        expect_now("R5 fast AC", 7'b001_10_00);

        phase = "R2"; bat_gt_top = 1; run(3); bat_gt_top = 0; run(12);
        expect_now("R2 glitch ignored", 7'b001_10_00);
        bat_gt_top = 1; run(6);
        expect_now("R2 not yet filtered at edge n+5", 7'b001_10_00);
        run(1);
        expect_now("R2 filtered at edge n+6", 7'b0);

        phase = "R6"; run(6);
        expect_now("R6 stop above 3.6V", 7'b0);
        bat_gt_top = 0;
        phase = "R7"; sys_active = 1; run(12);
        expect_now("R7 stop when system active", 7'b0);
        sys_active = 0; run(12);
        expect_now("R7 restart on backup", 7'b001_10_00);

        phase = "R8"; pre_off = 1; run(2);
        expect_now("R8 pre_off", 7'b0);
        pre_off = 0; run(3); acc_sup_en = 1; run(2);
        expect_now("R8 accessory supply", 7'b0);
        acc_sup_en = 0; run(3);

        phase = "R10"; chg_det = 0; vbus_det = 1; usb_host = 1; run(12);
        expect_now("R10 USB untyped", 7'b0);
        phase = "R4"; ckit_det = 1; run(12);
        expect_now("R4 host slow above 2.0V", 7'b010_01_00);
        phase = "R5"; usb_host = 0; run(12);
        expect_now("R5 fast USB charger", 7'b001_01_00);
        phase = "R9"; chg_det = 1; run(12);
        expect_now("R9 AC priority", 7'b001_10_00);

        phase = "R11"; bat_det = 0; bat_gt_low = 0; bat_gt_mid = 0; run(12);
        expect_now("R11 CV small start", 7'b100_10_01);
        load_dis = 1; run(2);
        expect_now("R11 load disabled", 7'b100_10_00);
        load_dis = 0; bat_gt_top = 1; run(12);
        expect_now("R11 hold above 3.6V", 7'b000_10_01);
        sys_active = 1; run(12);
        expect_now("R11 CV request", 7'b000_10_11);
        chg_det = 0; usb_host = 1; run(12);
        expect_now("R11 host no battery off", 7'b0);

        phase = "R12"; sys_active = 0; bat_gt_top = 0; bat_det = 1; usb_host = 0;
        bat_gt_low = 1; run(12);
        expect_now("R12 single scheme single path", 7'b010_01_00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles >= WD_LIMIT);
        checks++;
        errors++;
        $display("FAIL watchdog: cycles %0d expected below %0d", cycles, WD_LIMIT);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule